// File: doc/BRIEF.md
# Way Replacement Selector

This unit decides which way of a set-associative cache is given up when a new line must be brought in. It holds replacement history for every set on its own. The surrounding cache controller reports each hit or fill with an access notification that carries a set index and a way number. When it needs room, it raises a victim request with a set index and the per-way valid bits of that set. The unit answers with a done strobe and the chosen way. The unit keeps no tags and moves no data.

The policy is fixed at elaboration by a parameter. In the first policy, each set keeps a full recency ordering of its ways, and the least recently touched way is evicted. In the second policy, each way has one reference bit and each set has a rotating hand. The unit gives second chances, one way per cycle, until it meets a way whose bit is clear. Under both policies, an invalid way is always preferred. The associativity may be anything from 1 to 16 ways.

Top module: `repl_select`

## Requirements
- R1: Parameter `POLICY` selects the rule: 0 chooses the recency-stack policy and 1 chooses the reference-bit sweep; the same stimulus on a fresh unit gives way N-1 under policy 0 and way 0 under policy 1.
- R2: Under policy 0, an accepted access to way w of a set moves w to the most-recent position of that set's stack. The ways that stood ahead of w each move back one place, and the ways behind w keep their places.
- R3: Under policy 0, with all ways valid, the victim is the way at the least-recent end of the set's stack, and answering a victim request leaves the stack unchanged.
- R4: Under policy 1, an accepted access sets the reference bit of the touched way in that set.
- R5: Under policy 1, with all ways valid, the sweep begins at the set's hand. It clears each reference bit it finds set and moves on, wrapping from way N-1 to way 0. It stops at the first way whose bit is clear, and that way is the victim.
- R6: Under policy 1, after a swept victim v the set's hand points to way v+1, or to way 0 when v is N-1.
- R7: In `validMask`, bit i high means way i holds a line. If any bit is low, the victim is the lowest-numbered way whose bit is low, under either policy, and no replacement state changes.
- R8: After reset, every stack holds way i at position i (way 0 most recent, way N-1 least recent), all reference bits are clear, every hand is at way 0, `vicDone` is low and `busy` is low.
- R9: A request answered without a sweep raises `vicDone` in the cycle after the request. A sweep holds `busy` high for k cycles, where k is the number of ways inspected (at most N+1). `vicDone` rises together with the fall of `busy`.
- R10: An access notification is dropped when it arrives in the same cycle as a victim request, or while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access notification strobe |
| accSet | input | SET_W | Set index of the access |
| accWay | input | WAY_W | Way touched by the access |
| vicReq | input | 1 | Victim request strobe, taken when `busy` is low |
| vicSet | input | SET_W | Set index for the victim request |
| validMask | input | NUM_WAYS | Valid bit per way of the requested set |
| vicDone | output | 1 | One-cycle strobe: `vicWay` holds the answer |
| vicWay | output | WAY_W | Chosen victim way |
| busy | output | 1 | A reference-bit sweep is in progress |

## Verification
The hardest case to reach from the ports is the longest sweep. Every reference bit of a set must be set, with the hand at a nonzero way, so that the sweep clears all N bits and wraps back to its start. The stimulus touches every way of one set before asking for a victim. The random mix reuses a small number of sets, so bits pile up and hands drift away from way 0. Accesses are also held high for the whole length of a sweep, and placed in the same cycle as a request on the way the stack would evict, to show that such accesses are dropped.

// File: rtl/repl_pkg.sv
package repl_pkg;

  localparam int POLICY_LRU   = 0;
  localparam int POLICY_CLOCK = 1;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } ctrlState_t;

  typedef struct packed {
    logic touch;       // apply an access notification
    logic pickFast;    // answer a request at once (stack tail or invalid way)
    logic startSweep;  // latch set and hand, begin reference-bit sweep
    logic sweepClear;  // current way has its bit set: clear it and step
    logic sweepHit;    // current way has a clear bit: it is the victim
  } replStrobes_t;

endpackage

// File: rtl/repl_ctrl.sv
module repl_ctrl
  import repl_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int POLICY   = POLICY_LRU
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         accValid,
  input  logic         vicReq,
  input  logic         anyInvalid,
  input  logic         curRef,
  output replStrobes_t strobes,
  output logic         busy
);

  localparam bit IS_CLOCK = (POLICY == POLICY_CLOCK);
  localparam int CNT_W    = $clog2(NUM_WAYS + 2) + 1;

  ctrlState_t state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (vicReq) begin
          if (!IS_CLOCK || anyInvalid) begin
            strobes.pickFast = 1'b1;
          end else begin
            strobes.startSweep = 1'b1;
            stateNext          = ST_SWEEP;
          end
        end else if (accValid) begin
          strobes.touch = 1'b1;
        end
      end
      ST_SWEEP: begin
        if (curRef) begin
          strobes.sweepClear = 1'b1;
        end else begin
          strobes.sweepHit = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_SWEEP);

  // Sweep length watch: counts cycles already spent in the sweep state.
  logic [CNT_W-1:0] sweepCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                 sweepCnt <= '0;
    else if (state == ST_SWEEP) sweepCnt <= sweepCnt + 1'b1;
    else                       sweepCnt <= '0;
  end

  // R9
  sweep_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SWEEP) |-> (sweepCnt <= CNT_W'(NUM_WAYS)));

  // R10
  no_touch_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.touch);

endmodule

// File: rtl/repl_state.sv
module repl_state
  import repl_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 8,
  parameter int POLICY   = POLICY_LRU,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  replStrobes_t        strobes,
  input  logic [SET_W-1:0]    accSet,
  input  logic [WAY_W-1:0]    accWay,
  input  logic [SET_W-1:0]    vicSet,
  input  logic [NUM_WAYS-1:0] validMask,
  output logic                anyInvalid,
  output logic                curRef,
  output logic                vicDone,
  output logic [WAY_W-1:0]    vicWay
);

  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

  function automatic logic [WAY_W-1:0] nextWay(input logic [WAY_W-1:0] w);
    return (w == LAST_WAY) ? '0 : w + 1'b1;
  endfunction

  // Invalid-way preference, shared by both policies.
  logic [WAY_W-1:0] invIdx;
  always_comb begin
    invIdx = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (!validMask[i]) invIdx = WAY_W'(i);
    end
  end
  assign anyInvalid = ~&validMask;

  logic [WAY_W-1:0] policyWay;  // victim when no way is invalid, fast path
  logic [WAY_W-1:0] sweepWay;   // way under inspection during a sweep

  generate
    if (POLICY == POLICY_CLOCK) begin : g_clock
      logic [NUM_WAYS-1:0] refQ  [NUM_SETS];
      logic [WAY_W-1:0]    handQ [NUM_SETS];
      logic [SET_W-1:0]    sweepSetQ;
      logic [WAY_W-1:0]    curWayQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int s = 0; s < NUM_SETS; s++) begin
            refQ[s]  <= '0;
            handQ[s] <= '0;
          end
          sweepSetQ <= '0;
          curWayQ   <= '0;
        end else begin
          if (strobes.touch) refQ[accSet][accWay] <= 1'b1;
          if (strobes.startSweep) begin
            sweepSetQ <= vicSet;
            curWayQ   <= handQ[vicSet];
          end
          if (strobes.sweepClear) begin
            refQ[sweepSetQ][curWayQ] <= 1'b0;
            curWayQ                  <= nextWay(curWayQ);
          end
          if (strobes.sweepHit) handQ[sweepSetQ] <= nextWay(curWayQ);
        end
      end

      assign curRef    = refQ[sweepSetQ][curWayQ];
      assign sweepWay  = curWayQ;
      assign policyWay = handQ[vicSet];

      // R4
      ref_set_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobes.touch |=> refQ[$past(accSet)][$past(accWay)]);

      // R5
      ref_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobes.sweepClear |=> !refQ[$past(sweepSetQ)][$past(curWayQ)]);

      // R7
      hand_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobes.pickFast |=> handQ[$past(vicSet)] == $past(handQ[vicSet]));

    end else begin : g_lru
      logic [WAY_W-1:0] stackQ [NUM_SETS][NUM_WAYS];
      logic [WAY_W-1:0] rowOld [NUM_WAYS];
      logic [WAY_W-1:0] rowNew [NUM_WAYS];
      logic             seen;

      // Move-to-front of the touched way; positions behind it stay put.
      always_comb begin
        for (int i = 0; i < NUM_WAYS; i++) rowOld[i] = stackQ[accSet][i];
        seen      = 1'b0;
        rowNew[0] = accWay;
        for (int i = 1; i < NUM_WAYS; i++) begin
          if (rowOld[i-1] == accWay) seen = 1'b1;
          rowNew[i] = seen ? rowOld[i] : rowOld[i-1];
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int s = 0; s < NUM_SETS; s++) begin
            for (int i = 0; i < NUM_WAYS; i++) stackQ[s][i] <= WAY_W'(i);
          end
        end else if (strobes.touch) begin
          for (int i = 0; i < NUM_WAYS; i++) stackQ[accSet][i] <= rowNew[i];
        end
      end

      assign policyWay = stackQ[vicSet][NUM_WAYS-1];
      assign curRef    = 1'b0;
      assign sweepWay  = '0;

      // R2
      mru_front_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobes.touch |=> stackQ[$past(accSet)][0] == $past(accWay));

      // R3
      tail_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobes.pickFast |=> stackQ[$past(vicSet)][NUM_WAYS-1] == $past(stackQ[vicSet][NUM_WAYS-1]));
    end
  endgenerate

  // Answer register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vicDone <= 1'b0;
      vicWay  <= '0;
    end else begin
      vicDone <= strobes.pickFast | strobes.sweepHit;
      if (strobes.pickFast)      vicWay <= anyInvalid ? invIdx : policyWay;
      else if (strobes.sweepHit) vicWay <= sweepWay;
    end
  end

  // R9
  way_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    vicDone |-> (vicWay <= LAST_WAY));

endmodule

// File: rtl/repl_select.sv
module repl_select
  import repl_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 8,
  parameter int POLICY   = POLICY_LRU,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                accValid,
  input  logic [SET_W-1:0]    accSet,
  input  logic [WAY_W-1:0]    accWay,
  input  logic                vicReq,
  input  logic [SET_W-1:0]    vicSet,
  input  logic [NUM_WAYS-1:0] validMask,
  output logic                vicDone,
  output logic [WAY_W-1:0]    vicWay,
  output logic                busy
);

  replStrobes_t strobes;
  logic         anyInvalid;
  logic         curRef;

  repl_ctrl #(
    .NUM_WAYS (NUM_WAYS),
    .POLICY   (POLICY)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .accValid   (accValid),
    .vicReq     (vicReq),
    .anyInvalid (anyInvalid),
    .curRef     (curRef),
    .strobes    (strobes),
    .busy       (busy)
  );

  repl_state #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .POLICY   (POLICY)
  ) u_state (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .accSet     (accSet),
    .accWay     (accWay),
    .vicSet     (vicSet),
    .validMask  (validMask),
    .anyInvalid (anyInvalid),
    .curRef     (curRef),
    .vicDone    (vicDone),
    .vicWay     (vicWay)
  );

  // R7
  invalid_pick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vicDone && $past(vicReq && !busy && !(&validMask)))
      |-> ((($past(validMask) >> vicWay) & NUM_WAYS'(1)) == '0));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    vicDone |-> !busy);

endmodule

// File: tb/tb_repl_select.sv
module tb_repl_select;

  localparam int NS = 8;
  localparam int NW = 5;
  localparam int SW = 3;
  localparam int WW = 3;
  localparam logic [NW-1:0] FULL = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  // policy 0 unit
  logic          lAcc = 0, lVic = 0;
  logic [SW-1:0] lAccSet = 0, lVicSet = 0;
  logic [WW-1:0] lAccWay = 0;
  logic [NW-1:0] lMask = '1;
  logic          lDone, lBusy;
  logic [WW-1:0] lWay;

  // policy 1 unit
  logic          cAcc = 0, cVic = 0;
  logic [SW-1:0] cAccSet = 0, cVicSet = 0;
  logic [WW-1:0] cAccWay = 0;
  logic [NW-1:0] cMask = '1;
  logic          cDone, cBusy;
  logic [WW-1:0] cWay;

  repl_select #(.NUM_SETS(NS), .NUM_WAYS(NW), .POLICY(0)) dut (
    .clk(clk), .rstN(rstN), .accValid(lAcc), .accSet(lAccSet), .accWay(lAccWay),
    .vicReq(lVic), .vicSet(lVicSet), .validMask(lMask),
    .vicDone(lDone), .vicWay(lWay), .busy(lBusy));

  repl_select #(.NUM_SETS(NS), .NUM_WAYS(NW), .POLICY(1)) dutClk (
    .clk(clk), .rstN(rstN), .accValid(cAcc), .accSet(cAccSet), .accWay(cAccWay),
    .vicReq(cVic), .vicSet(cVicSet), .validMask(cMask),
    .vicDone(cDone), .vicWay(cWay), .busy(cBusy));

  int checks = 0;
  int fails  = 0;
  int lStack [NS][NW];
  bit cRef   [NS][NW];
  int cHand  [NS];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic int lowestInvalid(logic [NW-1:0] m);
    int r = -1;
    for (int i = NW - 1; i >= 0; i--) if (!m[i]) r = i;
    return r;
  endfunction

  task automatic lruTouch(int s, int w);
    int p = 0;
    @(negedge clk);
    lAcc = 1; lAccSet = SW'(s); lAccWay = WW'(w);
    @(negedge clk);
    lAcc = 0;
    for (int i = 0; i < NW; i++) if (lStack[s][i] == w) p = i;
    for (int i = p; i > 0; i--) lStack[s][i] = lStack[s][i-1];
    lStack[s][0] = w;
  endtask

  task automatic clkTouch(int s, int w);
    @(negedge clk);
    cAcc = 1; cAccSet = SW'(s); cAccWay = WW'(w);
    @(negedge clk);
    cAcc = 0;
    cRef[s][w] = 1'b1;
  endtask

  // holdWay >= 0 drives an access to that way in the request cycle (dropped: R10)
  task automatic lruVictim(int s, logic [NW-1:0] m, string req, int holdWay = -1);
    int lat, exp;
    @(negedge clk);
    lVic = 1; lVicSet = SW'(s); lMask = m;
    if (holdWay >= 0) begin lAcc = 1; lAccSet = SW'(s); lAccWay = WW'(holdWay); end
    @(negedge clk);
    lVic = 0; lAcc = 0; lat = 1;
    while (!lDone && lat < 40) begin @(negedge clk); lat++; end
    exp = (lowestInvalid(m) >= 0) ? lowestInvalid(m) : lStack[s][NW-1];
    check(req, int'(lWay), exp);
    check("R9 latency", lat, 1);
  endtask

  // holdWay >= 0 keeps an access asserted through request and sweep (dropped: R10)
  task automatic clkVictim(int s, logic [NW-1:0] m, string req, int holdWay = -1);
    int lat, exp, expLat, h, k;
    logic busyFirst;
    @(negedge clk);
    cVic = 1; cVicSet = SW'(s); cMask = m;
    if (holdWay >= 0) begin cAcc = 1; cAccSet = SW'(s); cAccWay = WW'(holdWay); end
    @(negedge clk);
    cVic = 0; lat = 1; busyFirst = cBusy;
    while (!cDone && lat < 40) begin @(negedge clk); lat++; end
    cAcc = 0;
    if (lowestInvalid(m) >= 0) begin
      exp = lowestInvalid(m); expLat = 1;
      check("R7 no sweep", int'(busyFirst), 0);
    end else begin
      h = cHand[s]; k = 0;
      while (cRef[s][h]) begin cRef[s][h] = 1'b0; h = (h + 1) % NW; k++; end
      exp = h; expLat = k + 2;
      cHand[s] = (h + 1) % NW;
      check("R9 busy", int'(busyFirst), 1);
    end
    check(req, int'(cWay), exp);
    check("R9 latency", lat, expLat);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < NS; s++) begin
      cHand[s] = 0;
      for (int i = 0; i < NW; i++) begin lStack[s][i] = i; cRef[s][i] = 1'b0; end
    end
    repeat (3) @(negedge clk);
    // R8: outputs quiet in and right after reset
    check("R8 done", int'(lDone), 0);
    check("R8 busy", int'(cBusy), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 done", int'(cDone), 0);

    // R1 / R8: fresh units differ by policy
    lruVictim(5, FULL, "R1");
    clkVictim(5, FULL, "R1");
    lruVictim(3, FULL, "R8");

    // R2 / R3: reorder a stack
    lruTouch(2, 4);
    lruTouch(2, 1);
    lruTouch(2, 4);
    lruVictim(2, FULL, "R3");
    lruTouch(2, 3);
    lruVictim(2, FULL, "R2");

    // R7: invalid preference on both
    lruVictim(2, 5'b10110, "R7");
    lruVictim(2, 5'b11011, "R7");
    clkVictim(2, 5'b01111, "R7");

    // R5 / R6: full sweep with wrap, then hand advance
    for (int w = 0; w < NW; w++) clkTouch(4, w);
    clkVictim(4, FULL, "R5");
    clkVictim(4, FULL, "R6");
    for (int w = 0; w < NW; w++) clkTouch(4, w);
    clkVictim(4, FULL, "R5");
    clkTouch(4, 3);
    clkVictim(4, FULL, "R4");

    // R10: accesses colliding with a request or a sweep are dropped
    lruVictim(1, FULL, "R10", lStack[1][NW-1]);
    lruVictim(1, FULL, "R10");
    for (int w = 0; w < NW; w++) clkTouch(6, w);
    clkVictim(6, FULL, "R10", 0);
    clkVictim(6, FULL, "R10");

    // random mix over a few sets
    for (int n = 0; n < 600; n++) begin
      int op = $urandom % 6;
      int s  = $urandom % 3;
      int w  = $urandom % NW;
      logic [NW-1:0] m = (($urandom % 4) == 0) ? NW'($urandom) : FULL;
      case (op)
        0, 1: lruTouch(s, w);
        2, 3: clkTouch(s, w);
        4:    lruVictim(s, m, "R3");
        default: clkVictim(s, m, "R5");
      endcase
    end

    finishRun();
  end

endmodule